// File: doc/BRIEF.md
# Burst Sample Frame Reader

This block fetches one complete inertial sample set from a sensor with a single burst transaction on SPI. A one-cycle `trig` pulse starts the burst. The block sends a 32-bit burst command whose code is selected by `mode`. It then releases chip select for a fixed settling gap and clocks in a twelve-word reply.

The reply carries a header word, ten payload words and a trailing CRC-32. The header is a normal register reply. It is protected by a 4-bit nibble check code and carries a 2-bit status vector. The payload is protected by a reflected CRC-32. Each payload word arrives most significant byte first, but the CRC is fed least significant byte first. The block updates the CRC one byte per clock cycle while the following word is still being shifted in, so the result is ready as soon as the last word lands.

When both checks pass, seven consecutive payload words (temperature, then three axes of one quantity, then three axes of the other) are copied to a registered parallel bus, and a one-cycle valid strobe is raised. When either check fails, the bus keeps its previous contents and a one-cycle error pulse is raised instead.

Top module: `burst_frame_reader`

## Requirements
- R1: A burst sends the command word MSB first on `spi_mosi`, with one bit per `spi_sclk` rising edge and 32 rising edges. The bytes in transmit order are 0x00, 0x00, the burst code, and a check byte. The burst code is 0x0A when `mode`=0 at the trigger and 0x0B when `mode`=1. The check byte is 0x0 in its upper nibble. Its lower nibble is 0xA XOR both nibbles of the code, which gives 0x00 for 0x0A and 0x01 for 0x0B.
- R2: After the command, `spi_cs_n` stays high for exactly GAP_CYC clock cycles (default 800, which is 8 µs at 100 MHz) before it falls again for the reply.
- R3: The reply is clocked in as 384 `spi_sclk` rising edges with `spi_cs_n` low. These are twelve 32-bit words, each MSB first, and `spi_miso` is sampled on the rising edge (mode 0). `spi_sclk` is low whenever `spi_cs_n` is high.
- R4: Header word 0 is accepted only when two conditions hold. Its bits [3:0] must equal 0xA XORed with the seven nibbles of bits [31:4]. Its status vector in bits [7:6] must be 0 or 1.
- R5: Word 11 must equal the CRC-32 over words 1 to 10. The CRC is reflected, with polynomial 0xEDB88320, initial value 0xFFFFFFFF and final XOR 0xFFFFFFFF. Each word is fed byte [7:0] first and byte [31:24] last. The header is not covered.
- R6: When both checks pass, `smp_valid` pulses high for one cycle. At that pulse `smp_data[32k+31:32k]` holds reply word 3+k for k=0..6.
- R7: When either check fails, `chk_err` pulses high for one cycle, `smp_valid` stays low, and `smp_data` keeps its previous value. Exactly one of the two pulses ends every burst.
- R8: A `trig` pulse that arrives while `busy` is high is ignored, and no further transaction follows.
- R9: Reset gives `spi_cs_n`=1, `spi_sclk`=0, `smp_valid`=0, `chk_err`=0, `busy`=0 and `smp_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Starts one burst when idle |
| mode | input | 1 | Burst type: 0 rate/accel, 1 delta angle/velocity |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the sensor |
| spi_miso | input | 1 | SPI data from the sensor |
| smp_data | output | 224 | Seven sample words, temperature in the lowest word |
| smp_valid | output | 1 | One-cycle strobe for a checked sample |
| chk_err | output | 1 | One-cycle pulse for a rejected frame |
| busy | output | 1 | Burst in progress |

## Verification
The hardest case to reach is a frame that is correct in every respect except one. Examples are a status vector of exactly 2 while the nibble check is correct, or a CRC broken only by a payload bit flipped after the CRC was computed. The sensor model on the bench builds each twelve-word reply from a seed. It computes the header check and the CRC arithmetically, then applies exactly one chosen corruption, so every rejection path is taken in both burst modes. A second trigger is also sent in the middle of a burst to show that it starts nothing.

// File: rtl/burst_rd_pkg.sv
package burst_rd_pkg;

  localparam logic [7:0]  CODE_RATE  = 8'h0A;
  localparam logic [7:0]  CODE_DELTA = 8'h0B;
  localparam logic [31:0] CRC_POLY   = 32'hEDB88320;
  localparam logic [3:0]  NIB_SEED   = 4'hA;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_GAP, S_RX, S_CHK
  } rd_state_t;

  // XOR of seed and the seven upper nibbles of a 32-bit word
  function automatic logic [3:0] nib_check(input logic [31:0] w);
    logic [3:0] c;
    c = NIB_SEED;
    for (int i = 1; i < 8; i++) c = c ^ w[4*i +: 4];
    return c;
  endfunction

  function automatic logic hdr_ok(input logic [31:0] w);
    return (w[3:0] == nib_check(w)) && (w[7:6] < 2'd2);
  endfunction

  // one byte of reflected CRC-32
  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

endpackage

// File: rtl/burst_spi_phy.sv
module burst_spi_phy #(
  parameter int WORD_W   = 32,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [WORD_W-1:0] rx_word
);
  localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BW = $clog2(WORD_W);
  localparam logic [HW-1:0] HALF_LAST = HW'(HALF_DIV - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(WORD_W - 1);

  logic              active;
  logic [HW-1:0]     half_cnt;
  logic [BW-1:0]     bit_cnt;
  logic [WORD_W-1:0] tx_sh;

  assign mosi = tx_sh[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      half_cnt <= '0;
      bit_cnt  <= '0;
      sclk     <= 1'b0;
      tx_sh    <= '0;
      rx_word  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active   <= 1'b1;
        tx_sh    <= tx_word;
        half_cnt <= '0;
        bit_cnt  <= '0;
        sclk     <= 1'b0;
      end else if (active) begin
        if (half_cnt == HALF_LAST) begin
          half_cnt <= '0;
          if (!sclk) begin
            sclk    <= 1'b1;
            rx_word <= {rx_word[WORD_W-2:0], miso};
          end else begin
            sclk  <= 1'b0;
            tx_sh <= tx_sh << 1;
            if (bit_cnt == BIT_LAST) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end else begin
          half_cnt <= half_cnt + 1'b1;
        end
      end
    end
  end

  a_r3_start_when_idle: assert property (@(posedge clk) disable iff (rst)
    start |-> !active);
  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r3_idle_clock_low: assert property (@(posedge clk) disable iff (rst)
    (!active && !start) |=> !sclk);

endmodule

// File: rtl/burst_crc_unit.sv
module burst_crc_unit
  import burst_rd_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic [31:0]       crc
);
  localparam int NBYTE = WORD_W / 8;
  localparam int CW    = $clog2(NBYTE + 1);

  logic [WORD_W-1:0] wsh;
  logic [CW-1:0]     left;

  // bytes leave least significant first
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc  <= 32'hFFFFFFFF;
      wsh  <= '0;
      left <= '0;
    end else if (load) begin
      wsh  <= word;
      left <= CW'(NBYTE);
    end else if (left != '0) begin
      crc  <= crc_byte(crc, wsh[7:0]);
      wsh  <= wsh >> 8;
      left <= left - 1'b1;
    end
  end

  a_r5_load_after_drain: assert property (@(posedge clk) disable iff (rst)
    load |-> (left == '0));
  a_r5_clear_seed: assert property (@(posedge clk) disable iff (rst)
    clr |=> (crc == 32'hFFFFFFFF));

endmodule

// File: rtl/burst_frame_reader.sv
module burst_frame_reader
  import burst_rd_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int N_WORDS   = 12,
  parameter int SMP_FIRST = 3,
  parameter int SMP_N     = 7,
  parameter int HALF_DIV  = 2,
  parameter int GAP_CYC   = 800
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    trig,
  input  logic                    mode,
  output logic                    spi_sclk,
  output logic                    spi_cs_n,
  output logic                    spi_mosi,
  input  logic                    spi_miso,
  output logic [SMP_N*WORD_W-1:0] smp_data,
  output logic                    smp_valid,
  output logic                    chk_err,
  output logic                    busy
);
  localparam int WIX = $clog2(N_WORDS);
  localparam int PIX = (SMP_N > 1) ? $clog2(SMP_N) : 1;
  localparam int GW  = $clog2(GAP_CYC + 1);
  localparam logic [WIX-1:0] W_LAST    = WIX'(N_WORDS - 1);
  localparam logic [WIX-1:0] CRC_LO    = WIX'(1);
  localparam logic [WIX-1:0] CRC_HI    = WIX'(N_WORDS - 2);
  localparam logic [WIX-1:0] SMP_LO    = WIX'(SMP_FIRST);
  localparam logic [WIX-1:0] SMP_HI    = WIX'(SMP_FIRST + SMP_N - 1);
  localparam logic [GW-1:0]  GAP_LAST  = GW'(GAP_CYC - 1);

  rd_state_t         state;
  logic [WIX-1:0]    widx;
  logic [GW-1:0]     gap_cnt;
  logic              phy_start, phy_done, hdr_good;
  logic [WORD_W-1:0] phy_tx, phy_rx;
  logic [31:0]       crc_q;
  logic              crc_clr, crc_load;
  logic [PIX-1:0]    pay_ix;
  logic [WORD_W-1:0] pay   [SMP_N];
  logic [WORD_W-1:0] smp_q [SMP_N];
  logic [7:0]        code_sel;
  logic [WORD_W-1:0] cmd_word;

  assign code_sel = mode ? CODE_DELTA : CODE_RATE;
  assign cmd_word = {16'h0000, code_sel, 4'h0, nib_check({16'h0000, code_sel, 8'h00})};
  assign crc_load = (state == S_RX) && phy_done && (widx >= CRC_LO) && (widx <= CRC_HI);
  assign crc_clr  = (state == S_IDLE) && trig;
  assign pay_ix   = PIX'(widx - SMP_LO);

  burst_spi_phy #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) i_phy (
    .clk(clk), .rst(rst), .start(phy_start), .tx_word(phy_tx), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .done(phy_done), .rx_word(phy_rx)
  );

  burst_crc_unit #(.WORD_W(WORD_W)) i_crc (
    .clk(clk), .rst(rst), .clr(crc_clr), .load(crc_load), .word(phy_rx), .crc(crc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      spi_cs_n  <= 1'b1;
      busy      <= 1'b0;
      phy_start <= 1'b0;
      phy_tx    <= '0;
      widx      <= '0;
      gap_cnt   <= '0;
      hdr_good  <= 1'b0;
      smp_valid <= 1'b0;
      chk_err   <= 1'b0;
    end else begin
      phy_start <= 1'b0;
      smp_valid <= 1'b0;
      chk_err   <= 1'b0;
      unique case (state)
        S_IDLE: if (trig) begin
          busy      <= 1'b1;
          spi_cs_n  <= 1'b0;
          phy_tx    <= cmd_word;
          phy_start <= 1'b1;
          state     <= S_CMD;
        end
        S_CMD: if (phy_done) begin
          spi_cs_n <= 1'b1;
          gap_cnt  <= '0;
          state    <= S_GAP;
        end
        S_GAP: begin
          if (gap_cnt == GAP_LAST) begin
            spi_cs_n  <= 1'b0;
            phy_tx    <= '0;
            phy_start <= 1'b1;
            widx      <= '0;
            state     <= S_RX;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        S_RX: if (phy_done) begin
          if (widx == '0) hdr_good <= hdr_ok(phy_rx);
          if (widx == W_LAST) begin
            spi_cs_n <= 1'b1;
            state    <= S_CHK;
          end else begin
            widx      <= widx + 1'b1;
            phy_start <= 1'b1;
          end
        end
        S_CHK: begin
          if (hdr_good && (phy_rx == ~crc_q)) smp_valid <= 1'b1;
          else                                chk_err   <= 1'b1;
          busy  <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // payload staging, then copy out only on a clean frame
  always_ff @(posedge clk) begin
    if (state == S_RX && phy_done && widx >= SMP_LO && widx <= SMP_HI)
      pay[pay_ix] <= phy_rx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < SMP_N; k++) smp_q[k] <= '0;
    end else if (state == S_CHK && hdr_good && (phy_rx == ~crc_q)) begin
      for (int k = 0; k < SMP_N; k++) smp_q[k] <= pay[k];
    end
  end

  for (genvar g = 0; g < SMP_N; g++) begin : g_out
    assign smp_data[g*WORD_W +: WORD_W] = smp_q[g];
  end

  a_r3_clock_quiet_deselected: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);
  a_r2_deselect_in_gap: assert property (@(posedge clk) disable iff (rst)
    (state == S_GAP) |-> spi_cs_n);
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (rst)
    !(smp_valid && chk_err));
  a_r6_valid_single: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> !smp_valid);
  a_r7_err_single: assert property (@(posedge clk) disable iff (rst)
    chk_err |=> !chk_err);
  a_r7_data_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(smp_data) |-> smp_valid);
  a_r8_idle_when_free: assert property (@(posedge clk) disable iff (rst)
    (!busy && !trig) |=> (!busy && spi_cs_n));

endmodule

// File: tb/test_burst_frame_reader.sv
module test_burst_frame_reader;
  localparam int GAP = 800;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         trig = 1'b0;
  logic         mode = 1'b0;
  logic         spi_miso = 1'b0;
  logic         spi_sclk, spi_cs_n, spi_mosi;
  logic [223:0] smp_data;
  logic         smp_valid, chk_err, busy;

  int n_chk = 0, n_err = 0, cyc = 0;

  // sensor model state
  int           phase = 0, idx = 0, cmd_rises = 0, rep_rises = 0, cs_falls = 0;
  logic [31:0]  cmd_sh = '0;
  logic [383:0] frame = '0;
  realtime      t_rise = 0;
  int           gap_meas = 0;
  logic [31:0]  prev [7];

  always #5 clk = ~clk;

  burst_frame_reader i_burst_frame_reader (
    .clk(clk), .rst(rst), .trig(trig), .mode(mode),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .smp_data(smp_data), .smp_valid(smp_valid), .chk_err(chk_err), .busy(busy)
  );

  always @(posedge clk) cyc++;

  always @(negedge spi_cs_n) begin
    cs_falls++;
    if (phase == 1) begin
      gap_meas = int'(($realtime - t_rise) / 10.0);
      idx = 0;
      spi_miso <= frame[383];
    end else begin
      spi_miso <= 1'b0;
    end
  end

  always @(posedge spi_cs_n) begin
    t_rise = $realtime;
    phase++;
  end

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      if (phase == 0) begin
        cmd_sh = {cmd_sh[30:0], spi_mosi};
        cmd_rises++;
      end else begin
        rep_rises++;
      end
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n && phase == 1) begin
      idx++;
      spi_miso <= (idx < 384) ? frame[383-idx] : 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] nib(input logic [31:0] w);
    logic [3:0] c = 4'hA;
    for (int i = 1; i < 8; i++) c ^= w[4*i +: 4];
    return c;
  endfunction

  function automatic logic [31:0] crc_of(input logic [31:0] w [12]);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 1; i <= 10; i++)
      for (int b = 0; b < 4; b++) begin
        c ^= {24'h0, w[i][8*b +: 8]};
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
    return ~c;
  endfunction

  // case: 0 sv0,1 sv1,2 sv2,3 sv3,4 bad nibble,5 bad crc,6 payload flip,7 both,8 ones,9 zeros
  task automatic build(input int cs, input int seed, output logic [31:0] w [12], output bit ok);
    logic [31:0] s = 32'h1234_5678 ^ (seed * 32'h9E37_79B9);
    logic [1:0]  sv;
    for (int i = 0; i < 12; i++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      w[i] = (cs == 8) ? 32'hFFFF_FFFF : (cs == 9) ? 32'h0 : s;
    end
    sv = (cs == 1) ? 2'd1 : (cs == 2) ? 2'd2 : (cs == 3) ? 2'd3 : 2'd0;
    w[0][7:6] = sv;
    w[0][3:0] = nib(w[0]);
    if (cs == 4 || cs == 7) w[0][3:0] ^= 4'h1;
    w[11] = crc_of(w);
    if (cs == 5 || cs == 7) w[11] ^= 32'h0000_0100;
    if (cs == 6) w[5] ^= 32'h0001_0000;
    ok = !(cs >= 2 && cs <= 7);
  endtask

  task automatic burst(input bit md, input logic [31:0] w [12], input bit ok, input bit retrig);
    int nv = 0, ne = 0, n = 0, f0;
    phase = 0; cmd_sh = '0; cmd_rises = 0; rep_rises = 0; gap_meas = 0;
    for (int i = 0; i < 12; i++) frame[383-32*i -: 32] = w[i];
    f0 = cs_falls;
    @(negedge clk); mode = md; trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    while (busy && n < 10000) begin
      if (retrig && n == 300) begin trig = 1'b1; mode = ~md; end
      else trig = 1'b0;
      @(negedge clk); n++;
      if (smp_valid) nv++;
      if (chk_err) ne++;
    end
    trig = 1'b0;
    chk("R1 command word", {32'h0, cmd_sh}, md ? 64'h0000_0B01 : 64'h0000_0A00);
    chk("R1 command edges", cmd_rises, 32);
    chk("R2 gap cycles", gap_meas, GAP);
    chk("R3 reply edges", rep_rises, 384);
    chk(ok ? "R6 valid count" : "R7 valid count", nv, ok ? 1 : 0);
    chk(ok ? "R6 err count" : "R4 R5 err count", ne, ok ? 0 : 1);
    for (int k = 0; k < 7; k++) begin
      if (ok) prev[k] = w[3+k];
      chk(ok ? "R6 sample word" : "R7 held word", smp_data[32*k +: 32], prev[k]);
    end
    if (retrig) begin
      repeat (40) @(negedge clk);
      chk("R8 falls per burst", cs_falls - f0, 2);
      chk("R8 idle after", busy, 0);
    end
  endtask

  initial begin
    logic [31:0] w [12];
    bit ok;
    for (int k = 0; k < 7; k++) prev[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 cs_n", spi_cs_n, 1);
    chk("R9 sclk", spi_sclk, 0);
    chk("R9 valid", smp_valid, 0);
    chk("R9 err", chk_err, 0);
    chk("R9 busy", busy, 0);
    chk("R9 data", {32'h0, |smp_data}, 0);
    for (int md = 0; md < 2; md++)
      for (int cs = 0; cs < 10; cs++) begin
        build(cs, md * 16 + cs, w, ok);
        burst(md[0], w, ok, 1'b0);
      end
    build(0, 77, w, ok);
    burst(1'b0, w, ok, 1'b1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=<190000", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule